// File: doc/BRIEF.md
# Three-Level Shoot-Through State Sequencer

This block drives the twelve gate signals of a three-phase, three-level neutral-point-clamped bridge that is fed from an impedance (Z-source) network. Each sampling period it plays one symmetric space-vector sequence for the selected triangle of the first sector. In most triangles it splices partial shoot-through states into that sequence so the impedance network can raise the DC link. In a partial shoot-through state, three of a leg's four switches are on. The surrounding modulator supplies a triangle code and the segment dwell times in clock cycles, including a total shoot-through budget. The block returns the gate word, the running segment index and a strobe that marks the first cycle of each period.

Each half period is built from six slots:
- slot 0: the outer null state;
- slot 1: a shoot-through state;
- slots 2 and 3: the inner states;
- slot 4: a second shoot-through state;
- slot 5: the inner null state.

The second half plays the slots in reverse order, which gives twelve segments numbered 0 to 11. The shoot-through time is taken only from the two null slots. The active states therefore keep their volt-seconds, and the period length does not depend on the boost.

Top module: `zst_seq`

## Requirements
- R1: Each leg drives a 4-bit field ordered {Q1, Q2, Q1', Q2'}: P=1100, O=0110, N=0011, upper shoot-through U=1110, lower shoot-through L=0111. Phase A occupies gate[11:8], B gate[7:4], C gate[3:0].
- R2: No leg ever shows 1111, and at most one leg is in a shoot-through state at a time. U appears only while the other two legs are at O or N. L appears only while the other two are at O or P.
- R3: Segment k (0..11) plays slot k for k<6 and slot 11-k otherwise. The slot states per triangle code are as follows. Code 1: ONN, UNN, ONN, PON, POL, POO. Code 2: PPO, PPL, POO, PON, UON, OON. Code 3: ONN, UNN, PNN, PON, POL, POO. Code 4: OON, UON, PON, PPN, PPL, PPO. A shoot-through state appears only in segments 1, 4, 7 and 10.
- R4: Let q be the smaller of floor(st_total/4), null_a and null_b. In every half period, slot 1 and slot 4 each last q cycles, slot 0 lasts null_a-q, slot 2 lasts act_1, slot 3 lasts act_2 and slot 5 lasts null_b-q. The period therefore lasts 2*(null_a+act_1+act_2+null_b) cycles.
- R5: Triangle code 0 plays the plain sequence ONN, ONN, OON, OOO, POO, POO with q forced to 0, so no shoot-through state ever appears.
- R6: A segment with zero dwell is skipped and occupies no cycle. If every segment of a period has zero dwell, the period lasts one cycle in the slot 0 state at segment 0.
- R7: The triangle code and all dwell inputs are sampled only on the first cycle of a period. Changes during a period take effect at the next period.
- R8: frame is high for exactly the first cycle of every period.
- R9: A synchronous reset sets all legs to O, the segment index to 0 and frame low. The first period starts on the first clock edge after reset is released.
- R10: Triangle codes 5 to 7 behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tri_sel | input | 3 | Triangle code within sector 1 |
| null_a | input | DW | Outer null dwell per half period, shoot-through included |
| act_1 | input | DW | Slot 2 dwell |
| act_2 | input | DW | Slot 3 dwell |
| null_b | input | DW | Inner null dwell per half period, shoot-through included |
| st_total | input | DW | Total partial shoot-through time per period |
| gate | output | 12 | Gate bits, three 4-bit leg fields |
| seg | output | 4 | Current segment index 0..11 |
| frame | output | 1 | First cycle of a period |

## Verification
The bench sweeps all eight triangle codes against five dwell patterns and runs two full periods per combination. The patterns are as follows:
- A generous pattern shows each triangle's state order and the symmetric replay.
- An oversized shoot-through budget checks the clamp to the shorter null.
- Two sparse patterns zero out different slots, separating zero-dwell skipping from wrong sequencing.
- An all-zero pattern exercises the one-cycle degenerate period.

Two further runs change the inputs in mid-period, to show they are sampled only at the period boundary.

// File: rtl/zst_seq.sv
module zst_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    tri_sel,
  input  logic [DW-1:0] null_a,
  input  logic [DW-1:0] act_1,
  input  logic [DW-1:0] act_2,
  input  logic [DW-1:0] null_b,
  input  logic [DW-1:0] st_total,
  output logic [11:0]   gate,
  output logic [3:0]    seg,
  output logic          frame
);
  localparam int NSEG  = 12;
  localparam int NSLOT = NSEG / 2;
  localparam logic [2:0] LN = 3'd0, LO = 3'd1, LP = 3'd2, LU = 3'd3, LL = 3'd4;
  localparam logic [11:0] ALL_O = 12'b0110_0110_0110;

  function automatic logic [3:0] leg_bits(input logic [2:0] c);
    case (c)
      LN:      return 4'b0011;
      LP:      return 4'b1100;
      LU:      return 4'b1110;
      LL:      return 4'b0111;
      default: return 4'b0110;
    endcase
  endfunction

  function automatic logic [8:0] slot_state(input logic [2:0] t, input logic [2:0] s);
    logic [8:0] r;
    r = {LO, LN, LN};
    case (t)
      3'd1: case (s)
        3'd0: r = {LO, LN, LN};  3'd1: r = {LU, LN, LN};
        3'd2: r = {LO, LN, LN};  3'd3: r = {LP, LO, LN};
        3'd4: r = {LP, LO, LL};  default: r = {LP, LO, LO};
      endcase
      3'd2: case (s)
        3'd0: r = {LP, LP, LO};  3'd1: r = {LP, LP, LL};
        3'd2: r = {LP, LO, LO};  3'd3: r = {LP, LO, LN};
        3'd4: r = {LU, LO, LN};  default: r = {LO, LO, LN};
      endcase
      3'd3: case (s)
        3'd0: r = {LO, LN, LN};  3'd1: r = {LU, LN, LN};
        3'd2: r = {LP, LN, LN};  3'd3: r = {LP, LO, LN};
        3'd4: r = {LP, LO, LL};  default: r = {LP, LO, LO};
      endcase
      3'd4: case (s)
        3'd0: r = {LO, LO, LN};  3'd1: r = {LU, LO, LN};
        3'd2: r = {LP, LO, LN};  3'd3: r = {LP, LP, LN};
        3'd4: r = {LP, LP, LL};  default: r = {LP, LP, LO};
      endcase
      default: case (s)
        3'd0, 3'd1: r = {LO, LN, LN};
        3'd2:       r = {LO, LO, LN};
        3'd3:       r = {LO, LO, LO};
        default:    r = {LP, LO, LO};
      endcase
    endcase
    return r;
  endfunction

  function automatic logic [11:0] gates_of(input logic [2:0] t, input logic [2:0] s);
    logic [8:0] st;
    st = slot_state(t, s);
    return {leg_bits(st[8:6]), leg_bits(st[5:3]), leg_bits(st[2:0])};
  endfunction

  function automatic logic [2:0] slot_of(input logic [3:0] k);
    return (k < 4'(NSLOT)) ? k[2:0] : 3'(4'(NSEG - 1) - k);
  endfunction

  logic [2:0]    cfg_t;
  logic [DW-1:0] cd [NSLOT];
  logic [DW-1:0] fd [NSLOT];
  logic [DW-1:0] cnt;
  logic [3:0]    seg_r;

  logic [2:0]    tn;
  logic [DW-1:0] q_raw, q;

  assign tn    = (tri_sel > 3'd4) ? 3'd0 : tri_sel;
  assign q_raw = st_total >> 2;

  always_comb begin
    q = q_raw;
    if (null_a < q) q = null_a;
    if (null_b < q) q = null_b;
    if (tn == 3'd0) q = '0;
    fd[0] = null_a - q;
    fd[1] = q;
    fd[2] = act_1;
    fd[3] = act_2;
    fd[4] = q;
    fd[5] = null_b - q;
  end

  logic       nxt_ok, f_ok;
  logic [3:0] nxt, first;

  always_comb begin
    nxt_ok = 1'b0;
    nxt    = '0;
    f_ok   = 1'b0;
    first  = '0;
    for (int k = NSEG - 1; k >= 0; k--) begin
      if (4'(k) > seg_r && cd[slot_of(4'(k))] != '0) begin
        nxt_ok = 1'b1;
        nxt    = 4'(k);
      end
      if (fd[slot_of(4'(k))] != '0) begin
        f_ok  = 1'b1;
        first = 4'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate  <= ALL_O;
      seg_r <= '0;
      frame <= 1'b0;
      cnt   <= '0;
      cfg_t <= '0;
      for (int i = 0; i < NSLOT; i++) cd[i] <= '0;
    end else if (cnt != '0) begin
      cnt   <= cnt - 1'b1;
      frame <= 1'b0;
    end else if (nxt_ok) begin
      seg_r <= nxt;
      cnt   <= cd[slot_of(nxt)] - 1'b1;
      gate  <= gates_of(cfg_t, slot_of(nxt));
      frame <= 1'b0;
    end else begin
      cfg_t <= tn;
      for (int i = 0; i < NSLOT; i++) cd[i] <= fd[i];
      seg_r <= f_ok ? first : 4'd0;
      cnt   <= f_ok ? fd[slot_of(first)] - 1'b1 : '0;
      gate  <= gates_of(tn, f_ok ? slot_of(first) : 3'd0);
      frame <= 1'b1;
    end
  end

  assign seg = seg_r;
endmodule

module zst_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic [11:0] gate,
  input logic [3:0]  seg,
  input logic        frame
);
  function automatic logic is_st(input logic [3:0] g);
    return g == 4'b1110 || g == 4'b0111;
  endfunction

  function automatic logic legal(input logic [11:0] g);
    logic [3:0] l [3];
    logic ok;
    int n;
    l[0] = g[11:8]; l[1] = g[7:4]; l[2] = g[3:0];
    ok = 1'b1;
    n  = 0;
    for (int i = 0; i < 3; i++) begin
      if (is_st(l[i])) n++;
      for (int j = 0; j < 3; j++) begin
        if (i != j && l[i] == 4'b1110 && !(l[j] == 4'b0110 || l[j] == 4'b0011)) ok = 1'b0;
        if (i != j && l[i] == 4'b0111 && !(l[j] == 4'b0110 || l[j] == 4'b1100)) ok = 1'b0;
      end
    end
    return ok && n <= 1;
  endfunction

  // R2
  no_full_st_chk: assert property (@(posedge clk) disable iff (rst)
    gate[11:8] != 4'hF && gate[7:4] != 4'hF && gate[3:0] != 4'hF);

  // R2
  st_legal_chk: assert property (@(posedge clk) disable iff (rst) legal(gate));

  // R3
  st_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (is_st(gate[11:8]) || is_st(gate[7:4]) || is_st(gate[3:0]))
      |-> (seg == 4'd1 || seg == 4'd4 || seg == 4'd7 || seg == 4'd10));

  // R3
  seg_range_chk: assert property (@(posedge clk) disable iff (rst) seg < 4'd12);

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (gate == 12'b0110_0110_0110 && seg == 4'd0 && !frame));
endmodule

bind zst_seq zst_seq_chk u_chk (.clk(clk), .rst(rst), .gate(gate), .seg(seg), .frame(frame));

// File: tb/zst_seq_bench.sv
module zst_seq_bench;
  localparam int CLK_P = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] tri_sel = '0;
  logic [DW-1:0] null_a = '0, act_1 = '0, act_2 = '0, null_b = '0, st_total = '0;
  logic [11:0] gate;
  logic [3:0] seg;
  logic frame;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [11:0] eg [512];
  logic [3:0]  es [512];
  logic        ef [512];

  always #(CLK_P/2) clk = ~clk;

  zst_seq #(.DW(DW)) u_zst_seq (
    .clk(clk), .rst(rst), .tri_sel(tri_sel), .null_a(null_a), .act_1(act_1),
    .act_2(act_2), .null_b(null_b), .st_total(st_total),
    .gate(gate), .seg(seg), .frame(frame));

  function automatic logic [3:0] enc(input byte c);
    case (c)
      "P": return 4'b1100;
      "N": return 4'b0011;
      "U": return 4'b1110;
      "L": return 4'b0111;
      default: return 4'b0110;
    endcase
  endfunction

  function automatic string seq_str(input int t, input int s);
    string a [6];
    case (t)
      1: a = '{"ONN", "UNN", "ONN", "PON", "POL", "POO"};
      2: a = '{"PPO", "PPL", "POO", "PON", "UON", "OON"};
      3: a = '{"ONN", "UNN", "PNN", "PON", "POL", "POO"};
      4: a = '{"OON", "UON", "PON", "PPN", "PPL", "PPO"};
      default: a = '{"ONN", "ONN", "OON", "OOO", "POO", "POO"};
    endcase
    return a[s];
  endfunction

  function automatic logic [11:0] word(input int t, input int s);
    string x;
    x = seq_str(t, s);
    return {enc(x[0]), enc(x[1]), enc(x[2])};
  endfunction

  task automatic expand(input int off, input int t, input int na, input int a1,
                        input int a2, input int nb, input int st, output int len);
    int tt, q, d [6], s;
    tt = (t > 4) ? 0 : t;
    q = st / 4;
    if (na < q) q = na;
    if (nb < q) q = nb;
    if (tt == 0) q = 0;
    d = '{na - q, q, a1, a2, q, nb - q};
    len = 0;
    for (int k = 0; k < 12; k++) begin
      s = (k < 6) ? k : 11 - k;
      for (int c = 0; c < d[s]; c++) begin
        eg[off+len] = word(tt, s);
        es[off+len] = 4'(k);
        ef[off+len] = (len == 0);
        len++;
      end
    end
    if (len == 0) begin
      eg[off] = word(tt, 0);
      es[off] = 4'd0;
      ef[off] = 1'b1;
      len = 1;
    end
  endtask

  task automatic chk(input string tag, input int i);
    logic full;
    checks++;
    full = gate[11:8] == 4'hF || gate[7:4] == 4'hF || gate[3:0] == 4'hF;
    if (gate !== eg[i] || seg !== es[i] || frame !== ef[i] || full) begin
      failures++;
      $display("FAIL %s (enc R1, strobe R8, R2) idx %0d: gate=%b seg=%0d frame=%b expected gate=%b seg=%0d frame=%b",
               tag, i, gate, seg, frame, eg[i], es[i], ef[i]);
    end
  endtask

  task automatic set_in(input int t, input int na, input int a1, input int a2,
                        input int nb, input int st);
    tri_sel = 3'(t); null_a = DW'(na); act_1 = DW'(a1);
    act_2 = DW'(a2); null_b = DW'(nb); st_total = DW'(st);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (gate !== 12'b0110_0110_0110 || seg !== 4'd0 || frame !== 1'b0) begin
      failures++;
      $display("FAIL R9 reset: gate=%b seg=%0d frame=%b expected gate=011001100110 seg=0 frame=0",
               gate, seg, frame);
    end
    rst = 1'b0;
  endtask

  task automatic run_one(input string tag, input int t, input int na, input int a1,
                         input int a2, input int nb, input int st);
    int len;
    set_in(t, na, a1, a2, nb, st);
    expand(0, t, na, a1, a2, nb, st, len);
    do_reset();
    for (int c = 0; c < 2 * len; c++) begin
      @(negedge clk);
      chk(tag, c % len);
    end
  endtask

  // R7: inputs changed mid-period only take effect at the next period
  task automatic run_switch(input int ta, input int tb);
    int la, lb;
    set_in(ta, 3, 2, 2, 3, 4);
    expand(0, ta, 3, 2, 2, 3, 4, la);
    expand(la, tb, 2, 1, 3, 4, 8, lb);
    do_reset();
    for (int c = 0; c < la + lb; c++) begin
      @(negedge clk);
      chk("R7", c);
      if (c == 1) set_in(tb, 2, 1, 3, 4, 8);
    end
  endtask

  initial begin
    string tag;
    for (int t = 0; t < 8; t++) begin
      tag = (t == 0) ? "R5" : (t > 4) ? "R10" : "R3";
      run_one(tag, t, 3, 2, 2, 3, 4);
      run_one((t == 0) ? "R5" : "R4", t, 4, 1, 3, 2, 20);
      run_one("R6", t, 2, 0, 3, 1, 0);
      run_one("R6", t, 1, 2, 0, 1, 4);
      run_one("R6", t, 0, 0, 0, 0, 0);
    end
    run_switch(3, 2);
    run_switch(0, 4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule